// File: doc/BRIEF.md
# I2C 16-bit GPIO Expander

This block is an I2C target that gives a controller access to sixteen general-purpose pins, arranged as two 8-bit ports. Each port has four 8-bit registers: a pin-level view, an output latch, a polarity mask for the pin-level view, and a direction mask. The controller sends the target address, then a command byte that picks one register. Each following byte goes to, or comes from, the other register of the same pair. This lets one transfer update or fetch both ports of a register kind.

SCL and SDA are sampled by the system clock through short synchronizers, so all of the logic runs in one clock domain. SDA leaves the block as an open-drain pull-down enable. On the pin side the block takes a 16-bit level bus and drives a 16-bit value bus and a 16-bit per-pin drive enable. Port 0 maps to pins 7:0 and port 1 maps to pins 15:8.

Top module: `gpx_expander`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal the fixed prefix 4'b0100 followed by addr_sel[2:0]. Bit 0 of that byte selects read (1) or write (0). Any other address gets no acknowledge, and no register changes.
- R2: In a write, the first byte after the address is a command byte. Bits [2:0] select register index 0 to 7, and the command is valid only when bits [7:3] are zero. The indexes are: 0/1 pin levels, 2/3 output latch, 4/5 polarity, 6/7 direction. An even index is port 0 and an odd index is port 1.
- R3: In a write, each data byte after the first goes to the register whose index differs from the previous one only in bit 0. Written to index 6, bytes A, B, C leave index 6 = C and index 7 = B.
- R4: In a read (a repeated START after the command, then the address with read set), the first byte comes from the selected index. Each byte the controller acknowledges makes the next byte come from the other register of the pair.
- R5: When the controller does not acknowledge a read byte, the target releases SDA and drives nothing more until the next START.
- R6: pin_oe[i] is the inverse of direction bit i. A 1 in the direction register makes the pin an input, with its driver off.
- R7: pin_out equals the output latches, and a read of index 2 or 3 returns the latch value whatever the pin levels are.
- R8: A read of index 0 or 1 returns the sampled pin levels XOR the polarity register of that port.
- R9: After reset, the direction registers are 0xFF, the output latches are 0xFF and the polarity registers are 0x00. So pin_oe = 0, pin_out = 16'hFFFF and sda_oe = 0.
- R10: The target acknowledges writes to index 0 or 1, and writes under an invalid command, but these writes change nothing. A read under an invalid command returns 0x00.
- R11: A write to one register leaves every other register unchanged.
- R12: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock level |
| sda_i | input | 1 | I2C data level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_sel | input | 3 | Low three bits of the target address |
| pin_in | input | 16 | Pin levels |
| pin_out | output | 16 | Output latch values |
| pin_oe | output | 16 | Per-pin drive enable |

## Verification
The assertions take for granted that SCL stays low for several system clocks after each falling edge. They also take for granted that SDA changes only while SCL is low, except for START and STOP, and that the controller never drives SDA during a byte or acknowledge the target owns. The bench drives each bit in four phases of eight clocks, so every SCL half-period is far longer than the synchronizer and output-register delay. It releases SDA before every target-owned slot, and it holds the pin levels steady for a whole transfer before any read.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int BYTE_W = 8;
  localparam int N_PORT = 2;
  localparam int IDX_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WR,
    ST_ACK,
    ST_RD,
    ST_MACK,
    ST_RLD
  } bus_state_t;

  localparam logic [1:0] KIND_PIN = 2'd0;
  localparam logic [1:0] KIND_OUT = 2'd1;
  localparam logic [1:0] KIND_POL = 2'd2;
  localparam logic [1:0] KIND_DIR = 2'd3;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {STAGES{RST_VAL}};
      prev <= RST_VAL;
    end else begin
      pipe <= {pipe[STAGES-2:0], d};
      prev <= pipe[STAGES-1];
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int PW = BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_PORT*PW-1:0]  pin_in,
  input  logic                  wr_en,
  input  logic                  wr_ok,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [PW-1:0]         wr_data,
  input  logic                  rd_ok,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [PW-1:0]         rd_data,
  output logic [N_PORT*PW-1:0]  pin_out,
  output logic [N_PORT*PW-1:0]  pin_oe
);
  localparam int W = N_PORT * PW;

  logic [W-1:0] pin_q, out_q, pol_q, dir_q, view;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_in;
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[p*PW +: PW] <= '1;
        pol_q[p*PW +: PW] <= '0;
        dir_q[p*PW +: PW] <= '1;
      end else if (wr_en && wr_ok && (wr_idx[0] == 1'(p))) begin
        case (wr_idx[2:1])
          KIND_OUT: out_q[p*PW +: PW] <= wr_data;
          KIND_POL: pol_q[p*PW +: PW] <= wr_data;
          KIND_DIR: dir_q[p*PW +: PW] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign view = pin_q ^ pol_q;

  always_comb begin
    rd_data = '0;
    if (rd_ok) begin
      case (rd_idx[2:1])
        KIND_PIN: rd_data = view [rd_idx[0]*PW +: PW];
        KIND_OUT: rd_data = out_q[rd_idx[0]*PW +: PW];
        KIND_POL: rd_data = pol_q[rd_idx[0]*PW +: PW];
        default:  rd_data = dir_q[rd_idx[0]*PW +: PW];
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpx_i2c_engine.sv
module gpx_i2c_engine
  import gpx_pkg::*;
#(
  parameter logic [3:0] DEV_BASE = 4'b0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [2:0]        addr_sel,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [IDX_W-1:0]  idx,
  output logic              idx_ok,
  output logic              wr_en,
  output logic              wr_ok,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe,
  output logic              busy
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  bus_state_t        state, after;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      after   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      idx     <= '0;
      idx_ok  <= 1'b1;
      wr_en   <= 1'b0;
      wr_ok   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state <= ST_IDLE;
      end else if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WR: begin
            if (scl_rise && bitcnt < CNT_W'(BYTE_W)) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == CNT_W'(BYTE_W)) begin
              bitcnt <= '0;
              case (state)
                ST_ADDR: begin
                  if (shreg[7:1] == {DEV_BASE, addr_sel}) begin
                    state <= ST_ACK;
                    if (shreg[0]) begin
                      after <= ST_RD;
                      shreg <= rd_data;
                    end else begin
                      after <= ST_CMD;
                    end
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ST_CMD: begin
                  idx    <= shreg[IDX_W-1:0];
                  idx_ok <= (shreg[BYTE_W-1:IDX_W] == '0);
                  state  <= ST_ACK;
                  after  <= ST_WR;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_ok   <= idx_ok;
                  wr_idx  <= idx;
                  wr_data <= shreg;
                  idx[0]  <= ~idx[0];
                  state   <= ST_ACK;
                  after   <= ST_WR;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state  <= after;
              bitcnt <= '0;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                state <= ST_MACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_s) begin
                state <= ST_IDLE;
              end else begin
                idx[0] <= ~idx[0];
                state  <= ST_RLD;
              end
            end
          end
          ST_RLD: begin
            shreg <= rd_data;
            if (scl_fall) begin
              state  <= ST_RD;
              bitcnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sda_oe <= 1'b0;
    else     sda_oe <= (state == ST_ACK) || (state == ST_RD && !shreg[BYTE_W-1]);
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
  import gpx_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_BASE    = 4'b0100
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  input  logic [2:0]                 addr_sel,
  input  logic [N_PORT*BYTE_W-1:0]   pin_in,
  output logic [N_PORT*BYTE_W-1:0]   pin_out,
  output logic [N_PORT*BYTE_W-1:0]   pin_oe
);
  logic [1:0] raw, lvl, up, dn;
  assign raw = {sda_i, scl_i};

  for (genvar s = 0; s < 2; s++) begin : g_sync
    gpx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
      .clk(clk), .rst(rst), .d(raw[s]),
      .q(lvl[s]), .rise(up[s]), .fall(dn[s])
    );
  end

  logic start_det, stop_det;
  assign start_det = lvl[0] & dn[1];
  assign stop_det  = lvl[0] & up[1];

  logic [IDX_W-1:0]  idx, wr_idx;
  logic              idx_ok, wr_en, wr_ok, busy;
  logic [BYTE_W-1:0] wr_data, rd_data;

  gpx_i2c_engine #(.DEV_BASE(DEV_BASE)) eng_i (
    .clk(clk), .rst(rst),
    .scl_rise(up[0]), .scl_fall(dn[0]),
    .start_det(start_det), .stop_det(stop_det),
    .sda_s(lvl[1]), .addr_sel(addr_sel), .rd_data(rd_data),
    .idx(idx), .idx_ok(idx_ok),
    .wr_en(wr_en), .wr_ok(wr_ok), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_oe(sda_oe), .busy(busy)
  );

  gpx_regfile #(.PW(BYTE_W)) regs_i (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .wr_en(wr_en), .wr_ok(wr_ok), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_ok(idx_ok), .rd_idx(idx), .rd_data(rd_data),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/gpx_expander_chk.sv
module gpx_expander_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         scl_i,
  input logic         sda_oe,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_out,
  input logic         wr_en,
  input logic         wr_ok,
  input logic [2:0]   wr_idx,
  input logic         busy
);
  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_out == '1 && !sda_oe));

  // R11
  no_stray_update_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(pin_oe) && $stable(pin_out)));

  // R10
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (!wr_ok || wr_idx[2:1] == 2'd0)) |=> ($stable(pin_oe) && $stable(pin_out)));

  // R5
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !sda_oe);

  // R12
  sda_change_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind gpx_expander gpx_expander_chk #(.W(16)) chk_i (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .pin_oe(pin_oe), .pin_out(pin_out),
  .wr_en(wr_en), .wr_ok(wr_ok), .wr_idx(wr_idx), .busy(busy)
);

// File: tb/gpx_expander_tb_top.sv
module gpx_expander_tb_top;
  localparam int Q = 8;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [6:0] MY_ADDR = {4'b0100, SEL};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tb_scl = 1'b1;
  logic        tb_low = 1'b0;
  logic        sda_oe;
  logic [15:0] pin_in = 16'h0000;
  logic [15:0] pin_out, pin_oe;
  logic        sda_line;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  assign sda_line = ~(tb_low | sda_oe);

  always #10 clk = ~clk;

  gpx_expander dut_i (
    .clk(clk), .rst(rst), .scl_i(tb_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(SEL), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic qd();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    tb_low = 1'b0; qd();
    tb_scl = 1'b1; qd();
    tb_low = 1'b1; qd();
    tb_scl = 1'b0;
  endtask

  task automatic i2c_stop();
    qd(); tb_low = 1'b1; qd();
    tb_scl = 1'b1; qd();
    tb_low = 1'b0; qd();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      qd(); tb_low = ~b[i]; qd();
      tb_scl = 1'b1; qd(); qd();
      tb_scl = 1'b0;
    end
    qd(); tb_low = 1'b0; qd();
    tb_scl = 1'b1; qd();
    ack = ~sda_line; qd();
    tb_scl = 1'b0;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    b = '0;
    for (int i = 7; i >= 0; i--) begin
      qd(); tb_low = 1'b0; qd();
      tb_scl = 1'b1; qd();
      b = {b[6:0], sda_line}; qd();
      tb_scl = 1'b0;
    end
    qd(); tb_low = mack; qd();
    tb_scl = 1'b1; qd(); qd();
    tb_scl = 1'b0;
    qd(); tb_low = 1'b0;
  endtask

  // write cmd then n bytes from data
  task automatic wr_seq(input logic [7:0] cmd, input logic [7:0] d0, input logic [7:0] d1,
                        input logic [7:0] d2, input int n, input string req);
    logic a;
    i2c_start();
    wr_byte({MY_ADDR, 1'b0}, a); chk({req, " addr ack"}, 16'(a), 16'd1);
    wr_byte(cmd, a);             chk({req, " cmd ack"}, 16'(a), 16'd1);
    if (n > 0) begin wr_byte(d0, a); chk({req, " data ack"}, 16'(a), 16'd1); end
    if (n > 1) begin wr_byte(d1, a); chk({req, " data ack"}, 16'(a), 16'd1); end
    if (n > 2) begin wr_byte(d2, a); chk({req, " data ack"}, 16'(a), 16'd1); end
    i2c_stop();
  endtask

  // set command, repeated start, read n bytes (last not acknowledged)
  task automatic rd_seq(input logic [7:0] cmd, input int n, output logic [7:0] r [4]);
    logic a;
    i2c_start();
    wr_byte({MY_ADDR, 1'b0}, a);
    wr_byte(cmd, a);
    i2c_start();
    wr_byte({MY_ADDR, 1'b1}, a);
    for (int i = 0; i < 4; i++) r[i] = '0;
    for (int i = 0; i < n; i++) rd_byte(i != n - 1 ? 1'b1 : 1'b0, r[i]);
    qd();
    chk("R5 sda released after nack", 16'(sda_oe), 16'd0);
    i2c_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] r [4];
    logic [7:0] pol0, pol1;
    logic [15:0] pins;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 pin_oe reset", pin_oe, 16'h0000);
    chk("R9 pin_out reset", pin_out, 16'hFFFF);
    chk("R9 sda_oe reset", 16'(sda_oe), 16'd0);
    rd_seq(8'h04, 2, r);
    chk("R9 polarity reset port0", 16'(r[0]), 16'h0000);
    chk("R9 polarity reset port1", 16'(r[1]), 16'h0000);

    // R1 address sweep
    for (int s = 0; s < 8; s++) begin
      i2c_start();
      wr_byte({4'b0100, 3'(s), 1'b0}, a);
      i2c_stop();
      chk($sformatf("R1 address low bits %0d", s), 16'(a), 16'(s == int'(SEL)));
    end
    i2c_start(); wr_byte({4'b0110, SEL, 1'b0}, a); i2c_stop();
    chk("R1 wrong prefix", 16'(a), 16'd0);
    i2c_start(); wr_byte({4'b0100, ~SEL, 1'b0}, a); wr_byte(8'h06, a); wr_byte(8'h00, a); i2c_stop();
    chk("R1 foreign write leaves pin_oe", pin_oe, 16'h0000);

    // R3 R6 write alternation into direction pair
    wr_seq(8'h06, 8'h0F, 8'hA5, 8'h3C, 3, "R3");
    chk("R3 R6 pin_oe after alternating write", pin_oe, ~16'hA53C);
    chk("R11 pin_out unchanged", pin_out, 16'hFFFF);

    // R7 output latch
    wr_seq(8'h02, 8'h5A, 8'hC3, 8'h00, 2, "R7");
    chk("R7 pin_out", pin_out, 16'hC35A);
    chk("R11 pin_oe unchanged", pin_oe, ~16'hA53C);

    // R4 R7 read alternation starting at index 3, pins differ
    pin_in = 16'h1234;
    rd_seq(8'h03, 4, r);
    chk("R4 R7 read idx3", 16'(r[0]), 16'h00C3);
    chk("R4 R7 read idx2", 16'(r[1]), 16'h005A);
    chk("R4 read idx3 again", 16'(r[2]), 16'h00C3);
    chk("R4 read idx2 again", 16'(r[3]), 16'h005A);
    rd_seq(8'h07, 3, r);
    chk("R4 R2 read idx7", 16'(r[0]), 16'h00A5);
    chk("R4 R2 read idx6", 16'(r[1]), 16'h003C);
    chk("R4 R2 read idx7 again", 16'(r[2]), 16'h00A5);

    // R8 polarity sweep
    for (int k = 0; k < 8; k++) begin
      pins = 16'(k * 16'h1357) ^ 16'hA0C5;
      pol0 = 8'(k * 29);
      pol1 = ~8'(k * 53);
      pin_in = pins;
      wr_seq(8'h04, pol0, pol1, 8'h00, 2, "R8");
      rd_seq(8'h00, 2, r);
      chk($sformatf("R8 port0 k=%0d", k), 16'(r[0]), 16'(pins[7:0] ^ pol0));
      chk($sformatf("R8 port1 k=%0d", k), 16'(r[1]), 16'(pins[15:8] ^ pol1));
    end

    // R10 ignored writes
    wr_seq(8'h00, 8'h00, 8'h00, 8'h00, 2, "R10");
    rd_seq(8'h00, 2, r);
    chk("R10 input write ignored p0", 16'(r[0]), 16'(pins[7:0] ^ pol0));
    chk("R10 input write ignored p1", 16'(r[1]), 16'(pins[15:8] ^ pol1));
    wr_seq(8'h0E, 8'h00, 8'h00, 8'h00, 2, "R10");
    chk("R10 invalid cmd pin_oe", pin_oe, ~16'hA53C);
    chk("R10 invalid cmd pin_out", pin_out, 16'hC35A);
    wr_seq(8'h0A, 8'h00, 8'h00, 8'h00, 2, "R10");
    chk("R10 invalid cmd 0x0A pin_out", pin_out, 16'hC35A);
    rd_seq(8'h0A, 2, r);
    chk("R10 invalid read byte0", 16'(r[0]), 16'h0000);
    chk("R10 invalid read byte1", 16'(r[1]), 16'h0000);

    // R11 single register write
    wr_seq(8'h05, 8'h81, 8'h00, 8'h00, 1, "R11");
    rd_seq(8'h04, 2, r);
    chk("R11 pol0 kept", 16'(r[0]), 16'(pol0));
    chk("R11 pol1 written", 16'(r[1]), 16'h0081);
    chk("R11 pin_out kept", pin_out, 16'hC35A);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule